// File: doc/BRIEF.md
# Read-to-Acquire Semaphore Bank

This block holds a bank of one-bit locks, one per function, that guard a shared timer resource. Several requesters reach the bank through a simple register bus. Each lock sits at its own address, spaced at a fixed byte stride above a base address. A read of a lock address returns the lock's busy bit as it stood before the read and sets that bit in the same operation. A single read therefore both tests and takes the lock. A requester that reads back 0 now owns the lock. A requester that reads back 1 did not get it and must read again later. Any write to a lock address clears the busy bit and so releases the lock.

Every port offers requests with `req_valid` and gets its answer one cycle later on `rsp_valid` / `rsp_rdata`. The bank never applies back-pressure. It accepts a request on every cycle in which `req_valid` is high, so there is no ready signal, and the requester must take each response in the cycle it appears. When several ports reach the same lock in the same cycle, a fixed priority decides which one wins: the port with the lowest index. No two requesters can ever both believe they own one lock.

Top module: `sem_bank`

## Requirements
- R1: A read of a lock address returns, in bit 0 of the response word, the busy bit as it stood before that read, for the highest-priority reader of that lock in that cycle.
- R2: A read of a free lock sets its busy bit, so the reader that sees 0 owns the lock and a later read returns 1.
- R3: A read of a busy lock returns 1 and leaves the lock busy.
- R4: A write to a lock address clears its busy bit, whatever its prior state. The write's response carries `rsp_valid` high and an all-zero data word.
- R5: Every response word has bits above bit 0 equal to zero.
- R6: Lock f answers at address BASE + f*STRIDE. A misaligned address or one outside the bank reads as zero, and a read or write there changes no lock.
- R7: When several ports read the same lock in one cycle, only the lowest-index port gets the true prior value. Every other port gets 1, so at most one reader sees 0.
- R8: A read and a write to the same lock in one cycle resolve as follows. If the lock was free, the read acquires it (the reader sees 0) and the write has no effect. If it was busy, the write releases it and the reader sees 1.
- R9: Reset clears every busy bit, and `rsp_valid` is low while reset is active.
- R10: Each request accepted in a cycle produces `rsp_valid` on that port exactly one cycle later, and `rsp_valid` is never high without a request one cycle before.
- R11: Locks are independent. Reads by different ports of different locks in the same cycle each acquire their own lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPORT | Per-port request strobe |
| req_write | input | NPORT | Per-port operation: 1 = write (release), 0 = read (test-and-set) |
| req_addr | input | NPORT*AW | Per-port byte address, port p in bits [p*AW +: AW] |
| rsp_valid | output | NPORT | Per-port response strobe, one cycle after the request |
| rsp_rdata | output | NPORT*DW | Per-port response word, port p in bits [p*DW +: DW] |

## Verification
Two kinds of operation can meet on one lock in the same cycle. The first is two test-and-set reads from different ports. The second is a test-and-set read on one port together with a release write on the other. The bench drives both ports in the same cycle toward one address. For the read-read case, it checks that only port 0 can see 0 and that port 1 sees 1. For the read-write case, it covers both a free lock and a held lock. It then judges the outcome by a follow-up read of the lock: the lock must remain held in the free case and must be released in the held case.

// File: rtl/sem_pkg.sv
package sem_pkg;

  // Operation carried by one port in one cycle after decode.
  typedef struct packed {
    logic hit;   // address selects a lock in the bank
    logic rd;    // test-and-set read of that lock
    logic wr;    // release write of that lock
  } sem_op_t;

  // Width of an index able to name n items (at least one bit).
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sem_addr_dec.sv
module sem_addr_dec #(
  parameter int unsigned AW     = 12,
  parameter int unsigned BASE   = 256,
  parameter int unsigned STRIDE = 4,
  parameter int unsigned NFUNC  = 4,
  localparam int unsigned IW    = sem_pkg::idx_width(NFUNC)
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [IW-1:0] idx
);
  localparam int unsigned SH   = $clog2(STRIDE);
  localparam int unsigned SPAN = NFUNC * STRIDE;

  logic [AW-1:0] off;

  always_comb begin
    off = addr - AW'(BASE);
    hit = (addr >= AW'(BASE)) && (off < AW'(SPAN)) && (off[SH-1:0] == '0);
    idx = off[SH +: IW];
  end
endmodule

// File: rtl/sem_prio_arb.sv
module sem_prio_arb #(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    gnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        gnt[i] = 1'b1;
        taken  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic take,   // at least one read of this lock this cycle
  input  logic rel,    // at least one write of this lock this cycle
  output logic busy
);
  logic busy_n;

  // Free lock: any read acquires it, a concurrent write is moot.
  // Held lock: a write releases it, a concurrent reader loses.
  always_comb busy_n = busy ? ~rel : take;

  always_ff @(posedge clk) begin
    if (!rst_n) busy <= 1'b0;
    else        busy <= busy_n;
  end
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int unsigned NPORT  = 2,
  parameter int unsigned NFUNC  = 4,
  parameter int unsigned AW     = 12,
  parameter int unsigned DW     = 32,
  parameter int unsigned BASE   = 256,
  parameter int unsigned STRIDE = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORT-1:0]    req_valid,
  input  logic [NPORT-1:0]    req_write,
  input  logic [NPORT*AW-1:0] req_addr,
  output logic [NPORT-1:0]    rsp_valid,
  output logic [NPORT*DW-1:0] rsp_rdata
);
  import sem_pkg::*;

  localparam int unsigned IW = idx_width(NFUNC);

  logic [IW-1:0]          port_idx [NPORT];
  logic [NPORT-1:0]       port_hit;
  sem_op_t                port_op  [NPORT];
  logic [NFUNC*NPORT-1:0] rd_hit_flat;
  logic [NFUNC*NPORT-1:0] wr_hit_flat;
  logic [NFUNC*NPORT-1:0] gnt_flat;
  logic [NFUNC-1:0]       rd_any;
  logic [NFUNC-1:0]       wr_any;
  logic [NFUNC-1:0]       busy_q;
  logic [NPORT*DW-1:0]    rdata_n;

  // Per-port address decode.
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    sem_addr_dec #(
      .AW(AW), .BASE(BASE), .STRIDE(STRIDE), .NFUNC(NFUNC)
    ) u_dec (
      .addr(req_addr[p*AW +: AW]),
      .hit (port_hit[p]),
      .idx (port_idx[p])
    );

    always_comb begin
      port_op[p].hit = port_hit[p];
      port_op[p].rd  = req_valid[p] & ~req_write[p] & port_hit[p];
      port_op[p].wr  = req_valid[p] &  req_write[p] & port_hit[p];
    end
  end

  // Spread each port's operation onto the lock it addresses.
  always_comb begin
    for (int f = 0; f < NFUNC; f++) begin
      for (int p = 0; p < NPORT; p++) begin
        rd_hit_flat[f*NPORT+p] = port_op[p].rd && (port_idx[p] == IW'(f));
        wr_hit_flat[f*NPORT+p] = port_op[p].wr && (port_idx[p] == IW'(f));
      end
    end
  end

  // One arbiter and one lock bit per function.
  for (genvar f = 0; f < NFUNC; f++) begin : g_lock
    sem_prio_arb #(.N(NPORT)) u_arb (
      .req(rd_hit_flat[f*NPORT +: NPORT]),
      .gnt(gnt_flat[f*NPORT +: NPORT])
    );

    assign rd_any[f] = |rd_hit_flat[f*NPORT +: NPORT];
    assign wr_any[f] = |wr_hit_flat[f*NPORT +: NPORT];

    sem_cell u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .take (rd_any[f]),
      .rel  (wr_any[f]),
      .busy (busy_q[f])
    );
  end

  // Response word: the winner sees the prior busy bit, losers see 1.
  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      logic won;
      logic bit0;
      won  = 1'b0;
      bit0 = 1'b0;
      for (int f = 0; f < NFUNC; f++) begin
        if (rd_hit_flat[f*NPORT+p]) begin
          won  = gnt_flat[f*NPORT+p];
          bit0 = busy_q[f] | ~won;
        end
      end
      rdata_n[p*DW +: DW] = DW'(bit0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= '0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= rdata_n;
    end
  end
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
  parameter int unsigned NPORT = 2,
  parameter int unsigned NFUNC = 4,
  parameter int unsigned DW    = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NPORT-1:0]       req_valid,
  input logic [NPORT-1:0]       rsp_valid,
  input logic [NPORT*DW-1:0]    rsp_rdata,
  input logic [NFUNC*NPORT-1:0] rd_hit_flat,
  input logic [NFUNC-1:0]       rd_any,
  input logic [NFUNC-1:0]       wr_any,
  input logic [NFUNC-1:0]       busy_q
);
  for (genvar p = 0; p < NPORT; p++) begin : g_p
    // R5: upper bits of a response are zero.
    p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[p] |-> (rsp_rdata[p*DW+1 +: DW-1] == '0));
    // R10: a request is answered one cycle later.
    p_rsp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[p] |=> rsp_valid[p]);
    // R10: no response without a request one cycle before.
    p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[p] |-> $past(req_valid[p]));
  end

  for (genvar f = 0; f < NFUNC; f++) begin : g_f
    // R1: top-priority reader sees the prior busy bit.
    p_prior_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit_flat[f*NPORT] |=> (rsp_rdata[0] == $past(busy_q[f])));
    // R2: a read of a free lock leaves it held.
    p_read_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_any[f] && !busy_q[f]) |=> busy_q[f]);
    // R3: a read of a held lock with no release keeps it held.
    p_stays_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_any[f] && busy_q[f] && !wr_any[f]) |=> busy_q[f]);
    // R4 / R8: a write to a held lock releases it.
    p_write_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_any[f] && busy_q[f]) |=> !busy_q[f]);
    // R6: a lock with no access keeps its state.
    p_untouched_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_any[f] && !wr_any[f]) |=> $stable(busy_q[f]));

    for (genvar p = 1; p < NPORT; p++) begin : g_hi
      for (genvar q = 0; q < p; q++) begin : g_lo
        // R7: a lower-priority reader of a contested lock sees 1.
        p_loser_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
          (rd_hit_flat[f*NPORT+p] && rd_hit_flat[f*NPORT+q])
            |=> rsp_rdata[p*DW]);
      end
    end
  end
endmodule

bind sem_bank sem_bank_chk #(
  .NPORT(NPORT), .NFUNC(NFUNC), .DW(DW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .rd_hit_flat(rd_hit_flat),
  .rd_any     (rd_any),
  .wr_any     (wr_any),
  .busy_q     (busy_q)
);

// File: tb/tb_sem_bank.sv
module tb_sem_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;
  localparam int AW = 12;
  localparam int DW = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NP-1:0]    req_valid = '0;
  logic [NP-1:0]    req_write = '0;
  logic [NP*AW-1:0] req_addr = '0;
  logic [NP-1:0]    rsp_valid;
  logic [NP*DW-1:0] rsp_rdata;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] r0, r1;

  sem_bank #(.NPORT(NP), .NFUNC(4), .AW(AW), .DW(DW), .BASE(256), .STRIDE(4)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [AW-1:0] lk(input int f);
    return AW'(256 + 4*f);
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle on both ports; responses sampled one cycle later (R10).
  task automatic xfer(input logic v0, input logic w0, input logic [AW-1:0] a0,
                      input logic v1, input logic w1, input logic [AW-1:0] a1,
                      output logic [DW-1:0] d0, output logic [DW-1:0] d1);
    @(negedge clk);
    req_valid = {v1, v0};
    req_write = {w1, w0};
    req_addr  = {a1, a0};
    @(negedge clk);
    req_valid = '0;
    req_write = '0;
    d0 = rsp_rdata[0 +: DW];
    d1 = rsp_rdata[DW +: DW];
    chk("R10", DW'(rsp_valid), DW'({v1, v0}));
  endtask

  task automatic rd0(input logic [AW-1:0] a, output logic [DW-1:0] d);
    logic [DW-1:0] dx;
    xfer(1'b1, 1'b0, a, 1'b0, 1'b0, '0, d, dx);
  endtask

  task automatic wr0(input logic [AW-1:0] a);
    logic [DW-1:0] d, dx;
    xfer(1'b1, 1'b1, a, 1'b0, 1'b0, '0, d, dx);
    chk("R4", d, 0);
  endtask

  task automatic t_reset;
    logic [DW-1:0] d;
    chk("R9", DW'(rsp_valid), 0);
    for (int f = 0; f < 4; f++) begin
      rd0(lk(f), d);
      chk("R9", d, 0);
    end
    rd0(lk(0), d);
    chk("R3", d, 1);
    for (int f = 0; f < 4; f++) wr0(lk(f));
    rd0(lk(3), d);
    chk("R4", d, 0);
    wr0(lk(3));
  endtask

  task automatic t_basic;
    logic [DW-1:0] d;
    rd0(lk(1), d);
    chk("R1", d, 0);
    rd0(lk(1), d);
    chk("R2", d, 1);
    chk("R5", d, 32'h1);
    rd0(lk(1), d);
    chk("R3", d, 1);
    wr0(lk(1));
    rd0(lk(1), d);
    chk("R4", d, 0);
    wr0(lk(1));
  endtask

  task automatic t_map;
    logic [DW-1:0] d, dx;
    xfer(1'b0, 1'b0, '0, 1'b1, 1'b0, lk(2), dx, d);
    chk("R6", d, 0);
    rd0(12'h109, d);      chk("R6", d, 0);
    rd0(12'h110, d);      chk("R6", d, 0);
    rd0(12'h0FC, d);      chk("R6", d, 0);
    wr0(12'h10A);
    wr0(12'h110);
    rd0(lk(2), d);
    chk("R6", d, 1);
    wr0(lk(2));
    rd0(lk(2), d);
    chk("R6", d, 0);
    wr0(lk(2));
  endtask

  task automatic t_race_rd;
    logic [DW-1:0] d0, d1;
    xfer(1'b1, 1'b0, lk(3), 1'b1, 1'b0, lk(3), d0, d1);
    chk("R7", d0, 0);
    chk("R7", d1, 1);
    xfer(1'b1, 1'b0, lk(3), 1'b1, 1'b0, lk(3), d0, d1);
    chk("R7", d0, 1);
    chk("R7", d1, 1);
    wr0(lk(3));
  endtask

  task automatic t_race_rw;
    logic [DW-1:0] d0, d1;
    rd0(lk(0), d0);
    chk("R8", d0, 0);
    xfer(1'b1, 1'b1, lk(0), 1'b1, 1'b0, lk(0), d0, d1);
    chk("R8", d1, 1);
    rd0(lk(0), d0);
    chk("R8", d0, 0);
    wr0(lk(0));
    xfer(1'b1, 1'b0, lk(0), 1'b1, 1'b1, lk(0), d0, d1);
    chk("R8", d0, 0);
    rd0(lk(0), d0);
    chk("R8", d0, 1);
    wr0(lk(0));
  endtask

  task automatic t_indep;
    logic [DW-1:0] d0, d1;
    xfer(1'b1, 1'b0, lk(1), 1'b1, 1'b0, lk(2), d0, d1);
    chk("R11", d0, 0);
    chk("R11", d1, 0);
    rd0(lk(1), d0);  chk("R11", d0, 1);
    rd0(lk(2), d0);  chk("R11", d0, 1);
    rd0(lk(3), d0);  chk("R11", d0, 0);
    wr0(lk(1)); wr0(lk(2)); wr0(lk(3));
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", DW'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_map();
    t_race_rd();
    t_race_rw();
    t_indep();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule